// File: doc/BRIEF.md
# Multi-Width Masked-Count Shifter

This unit shifts an operand of 8, 16, 32 or 64 bits to the left, or to the right with either zero fill or sign fill. The shift amount comes either from an 8-bit immediate field or from the lowest byte of a dedicated 64-bit count register. The unit reduces the count to the low log2(w) bits for the selected width w. An oversize count therefore wraps around and does not saturate.

The width-sized result is folded into the previous 64-bit destination value under register write rules. An 8-bit or 16-bit result overwrites only the low bytes and keeps the rest of the destination. A 32-bit result clears the upper half. A 64-bit result replaces the whole value.

The datapath is combinational. One output register stage captures it on every cycle in which the valid strobe is high.

Top module: `mwshift_unit`

## Requirements
- R1: `width_sel` selects the operand width w: code 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Only operand bits w-1..0 take part in the shift.
- R2: `op_sel` code 0 is a left shift and fills vacated low bits with zeros. Code 3 is the arithmetic form of the left shift and gives the same result as code 0.
- R3: `op_sel` code 1 is a logical right shift and fills vacated upper bits of the w-bit field with zeros.
- R4: `op_sel` code 2 is an arithmetic right shift and fills with operand bit w-1, which is not bit 63 unless w is 64.
- R5: Only the low log2(w) bits of the count are used. A count of 0xFF shifts an 8, 16, 32 or 64-bit left shift by 7, 15, 31 or 63 places respectively.
- R6: When `cnt_from_reg` is 1, the count is `cnt_reg[7:0]` and bits 63..8 of `cnt_reg` have no effect. When it is 0, the count is `imm_cnt` and `cnt_reg` is ignored.
- R7: For widths of 8 and 16 bits, bits 63..w of the result equal the same bits of `dest_old`.
- R8: For a width of 32 bits, result bits 63..32 are zero. For a width of 64 bits, the whole result is the shifted value.
- R9: When the masked count is zero, the low w bits of the result equal the operand's low w bits.
- R10: `result` and `out_valid` change one clock edge after a cycle with `in_valid` high. In a cycle with `in_valid` low, `result` holds and `out_valid` goes low. A synchronous reset clears both to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe that captures a new result |
| operand | input | 64 | Value to shift; low w bits used |
| width_sel | input | 2 | Width code (0:8, 1:16, 2:32, 3:64) |
| op_sel | input | 2 | Operation code (0:left, 1:logical right, 2:arithmetic right, 3:left) |
| cnt_from_reg | input | 1 | 1 selects the count register byte, 0 the immediate |
| imm_cnt | input | 8 | Immediate count |
| cnt_reg | input | 64 | Count register; only bits 7..0 used |
| dest_old | input | 64 | Prior destination value for merging |
| out_valid | output | 1 | Result register loaded on the previous edge |
| result | output | 64 | Merged destination value |

## Verification
The count of 0xFF is applied to left shifts at each width, and the four resulting amounts expose any masking that uses the wrong bit count. Arithmetic right shifts are tried on operands whose bit w-1 and bit 63 differ, which tells apart sign fill taken from the selected width from fill taken from the full word. A register count carrying junk above its low byte, with a different immediate present, shows which source is used. Counts of exactly w, and pseudo-random mixes of all codes checked against an independent model, cover the wrap-to-zero case and the merge rules.

// File: rtl/mws_pkg.sv
package mws_pkg;

  typedef enum logic [1:0] {
    W_BYTE  = 2'd0,
    W_HALF  = 2'd1,
    W_WORD  = 2'd2,
    W_QUAD  = 2'd3
  } mws_width_e;

  typedef enum logic [1:0] {
    OP_SHL = 2'd0,
    OP_SHR = 2'd1,
    OP_SAR = 2'd2,
    OP_SAL = 2'd3
  } mws_op_e;

  function automatic logic op_is_right(mws_op_e op);
    return (op == OP_SHR) || (op == OP_SAR);
  endfunction

  function automatic logic op_is_arith(mws_op_e op);
    return op == OP_SAR;
  endfunction

endpackage

// File: rtl/mws_count_sel.sv
module mws_count_sel
  import mws_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8,
  parameter int CREG_W = 64
) (
  input  logic                        cnt_from_reg,
  input  logic [CNT_W-1:0]            imm_cnt,
  input  logic [CREG_W-1:0]           cnt_reg,
  input  mws_width_e                  width,
  output logic [$clog2(DATA_W)-1:0]   masked_cnt
);
  localparam int MC_W = $clog2(DATA_W);

  logic [CNT_W-1:0] raw_cnt;
  logic [MC_W:0]    lane_bits;
  logic [MC_W-1:0]  lane_mask;

  always_comb begin
    raw_cnt    = cnt_from_reg ? cnt_reg[CNT_W-1:0] : imm_cnt;
    lane_bits  = (MC_W+1)'(8) << width;
    lane_mask  = MC_W'(lane_bits - (MC_W+1)'(1));
    masked_cnt = raw_cnt[MC_W-1:0] & lane_mask;
  end

endmodule

// File: rtl/mws_shift_core.sv
module mws_shift_core
  import mws_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]          operand,
  input  mws_width_e                 width,
  input  mws_op_e                    op,
  input  logic [$clog2(DATA_W)-1:0]  cnt,
  output logic [DATA_W-1:0]          shifted
);
  localparam int MC_W  = $clog2(DATA_W);
  localparam int LANES = MC_W - 2;

  logic [LANES-1:0][DATA_W-1:0] lane_out;
  logic go_right;
  logic go_arith;

  assign go_right = op_is_right(op);
  assign go_arith = op_is_arith(op);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int LW = 8 << k;
    localparam int SH = 3 + k;

    logic [SH:0][LW-1:0] stage;
    logic                fill;

    assign stage[0] = operand[LW-1:0];
    assign fill     = go_arith & operand[LW-1];

    for (genvar s = 0; s < SH; s++) begin : g_stage
      localparam int AMT = 1 << s;
      logic [LW-1:0] moved;
      always_comb begin
        if (go_right)
          moved = {{AMT{fill}}, stage[s][LW-1:AMT]};
        else
          moved = {stage[s][LW-1-AMT:0], {AMT{1'b0}}};
      end
      assign stage[s+1] = cnt[s] ? moved : stage[s];
    end

    if (LW == DATA_W) begin : g_full
      assign lane_out[k] = stage[SH];
    end else begin : g_part
      assign lane_out[k] = {{(DATA_W-LW){1'b0}}, stage[SH]};
    end
  end

  always_comb begin
    shifted = '0;
    for (int k = 0; k < LANES; k++) begin
      if (int'(width) == k) shifted = lane_out[k];
    end
  end

endmodule

// File: rtl/mws_merge.sv
module mws_merge
  import mws_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int ZERO_EXT_W = 32
) (
  input  logic [DATA_W-1:0] dest_old,
  input  logic [DATA_W-1:0] lane_res,
  input  mws_width_e        width,
  output logic [DATA_W-1:0] merged
);
  localparam int MC_W = $clog2(DATA_W);

  logic [MC_W:0]       lane_bits;
  logic [DATA_W-1:0]   lane_mask;
  logic                keep_upper;

  always_comb begin
    lane_bits  = (MC_W+1)'(8) << width;
    keep_upper = int'(lane_bits) < ZERO_EXT_W;
    lane_mask  = '0;
    for (int b = 0; b < DATA_W; b++) begin
      if (b < int'(lane_bits)) lane_mask[b] = 1'b1;
    end
    if (keep_upper)
      merged = (dest_old & ~lane_mask) | (lane_res & lane_mask);
    else
      merged = lane_res & lane_mask;
  end

endmodule

// File: rtl/mwshift_unit.sv
module mwshift_unit
  import mws_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int CNT_W      = 8,
  parameter int CREG_W     = 64,
  parameter int ZERO_EXT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [63:0]       operand,
  input  logic [1:0]        width_sel,
  input  logic [1:0]        op_sel,
  input  logic              cnt_from_reg,
  input  logic [7:0]        imm_cnt,
  input  logic [63:0]       cnt_reg,
  input  logic [63:0]       dest_old,
  output logic              out_valid,
  output logic [63:0]       result
);
  localparam int MC_W = $clog2(DATA_W);

  mws_width_e        width;
  mws_op_e           op;
  logic [MC_W-1:0]   masked_cnt;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] merged;

  assign width = mws_width_e'(width_sel);
  assign op    = mws_op_e'(op_sel);

  mws_count_sel #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .CREG_W (CREG_W)
  ) i_count_sel (
    .cnt_from_reg (cnt_from_reg),
    .imm_cnt      (imm_cnt),
    .cnt_reg      (cnt_reg),
    .width        (width),
    .masked_cnt   (masked_cnt)
  );

  mws_shift_core #(
    .DATA_W (DATA_W)
  ) i_shift_core (
    .operand (operand),
    .width   (width),
    .op      (op),
    .cnt     (masked_cnt),
    .shifted (shifted)
  );

  mws_merge #(
    .DATA_W     (DATA_W),
    .ZERO_EXT_W (ZERO_EXT_W)
  ) i_merge (
    .dest_old (dest_old),
    .lane_res (shifted),
    .width    (width),
    .merged   (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= merged;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && !out_valid)); // R10
  AST_BYTE_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
    (in_valid && width_sel == 2'd0) |=> result[63:8] == $past(dest_old[63:8])); // R7
  AST_WORD_ZEROS_UPPER: assert property (@(posedge clk) disable iff (rst)
    (in_valid && width_sel == 2'd2) |=> result[63:32] == 32'd0); // R8
  AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && width_sel == 2'd3 && masked_cnt == '0) |=> result == $past(operand)); // R9
  AST_SAR_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && width_sel == 2'd3 && op_sel == 2'd2 && operand[63]) |=> result[63]); // R4
  AST_SHR_ZERO_TOP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && width_sel == 2'd3 && op_sel == 2'd1 && masked_cnt != '0) |=> !result[63]); // R3
  AST_SHL_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && width_sel == 2'd3 && !op_is_right(op) && masked_cnt != '0) |=> !result[0]); // R2

endmodule

// File: tb/test_mwshift_unit.sv
`timescale 1ns/1ps
module test_mwshift_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] operand = '0;
  logic [1:0]  width_sel = '0;
  logic [1:0]  op_sel = '0;
  logic        cnt_from_reg = 1'b0;
  logic [7:0]  imm_cnt = '0;
  logic [63:0] cnt_reg = '0;
  logic [63:0] dest_old = '0;
  logic        out_valid;
  logic [63:0] result;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  mwshift_unit i_mwshift_unit (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .operand      (operand),
    .width_sel    (width_sel),
    .op_sel       (op_sel),
    .cnt_from_reg (cnt_from_reg),
    .imm_cnt      (imm_cnt),
    .cnt_reg      (cnt_reg),
    .dest_old     (dest_old),
    .out_valid    (out_valid),
    .result       (result)
  );

  function automatic logic [63:0] model(logic [1:0] op, logic [1:0] ws, logic src,
      logic [7:0] imm, logic [63:0] creg, logic [63:0] a_in, logic [63:0] dest);
    int w;
    int m;
    logic [7:0]  c;
    logic [63:0] lm;
    logic [63:0] a;
    logic [63:0] r;
    logic signed [63:0] sx;
    w  = 8 << ws;
    c  = src ? creg[7:0] : imm;
    m  = int'(c) & (w - 1);
    lm = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    a  = a_in & lm;
    sx = a[w-1] ? (a | ~lm) : a;
    case (op)
      2'd1:    r = a >> m;
      2'd2:    r = 64'(sx >>> m) & lm;
      default: r = (a << m) & lm;
    endcase
    if (ws < 2) return (dest & ~lm) | r;
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] op, logic [1:0] ws, logic src, logic [7:0] imm,
      logic [63:0] creg, logic [63:0] a, logic [63:0] dest, string tag);
    @(negedge clk);
    in_valid     = 1'b1;
    op_sel       = op;
    width_sel    = ws;
    cnt_from_reg = src;
    imm_cnt      = imm;
    cnt_reg      = creg;
    operand      = a;
    dest_old     = dest;
    exp_q.push_back(model(op, ws, src, imm, creg, a, dest));
    tag_q.push_back(tag);
  endtask

  task automatic drive_exp(logic [1:0] op, logic [1:0] ws, logic src, logic [7:0] imm,
      logic [63:0] creg, logic [63:0] a, logic [63:0] dest, logic [63:0] hand, string tag);
    drive(op, ws, src, imm, creg, a, dest, tag);
    void'(exp_q.pop_back());
    exp_q.push_back(hand);
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected out_valid", 64'd1, 64'd0);
      end else begin
        check(tag_q.pop_front(), result, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    check("R10 reset result", result, 64'd0);
    check("R10 reset out_valid", {63'd0, out_valid}, 64'd0);
    rst = 1'b0;

    // R1 R2: byte left shift, upper destination kept (R7)
    drive_exp(2'd0, 2'd0, 1'b0, 8'd1, 64'd0, 64'hFFFF_FFFF_FFFF_FF81,
              64'h1122_3344_5566_7788, 64'h1122_3344_5566_7702, "R1 R2 R7 byte shl");
    // R5: count 0xFF at every width
    drive_exp(2'd0, 2'd0, 1'b0, 8'hFF, 64'd0, 64'd1, 64'd0, 64'h80, "R5 byte 0xFF");
    drive_exp(2'd0, 2'd1, 1'b0, 8'hFF, 64'd0, 64'd1, 64'd0, 64'h8000, "R5 half 0xFF");
    drive_exp(2'd0, 2'd2, 1'b0, 8'hFF, 64'd0, 64'd1, 64'hFFFF_FFFF_0000_0000,
              64'h8000_0000, "R5 R8 word 0xFF");
    drive_exp(2'd0, 2'd3, 1'b0, 8'hFF, 64'd0, 64'd1, 64'd0, 64'h8000_0000_0000_0000,
              "R5 quad 0xFF");
    // R3: logical right on half
    drive_exp(2'd1, 2'd1, 1'b0, 8'd3, 64'd0, 64'h0000_0000_0000_8000,
              64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_1000, "R3 R7 half shr");
    // R4: arithmetic right uses bit w-1
    drive_exp(2'd2, 2'd0, 1'b0, 8'd2, 64'd0, 64'h0000_0000_0000_0080, 64'd0,
              64'hE0, "R4 byte sar neg");
    drive_exp(2'd2, 2'd0, 1'b0, 8'd2, 64'd0, 64'h8000_0000_0000_0040, 64'd0,
              64'h10, "R4 byte sar bit63 ignored");
    drive_exp(2'd2, 2'd2, 1'b0, 8'd4, 64'd0, 64'h0000_0000_8000_0000,
              64'h1234_5678_0000_0000, 64'h0000_0000_F800_0000, "R4 R8 word sar");
    drive_exp(2'd2, 2'd3, 1'b0, 8'd60, 64'd0, 64'h8000_0000_0000_0000, 64'd0,
              64'hFFFF_FFFF_FFFF_FFF8, "R4 R8 quad sar");
    // R2: op code 3 equals op code 0
    drive_exp(2'd3, 2'd1, 1'b0, 8'd4, 64'd0, 64'h0000_0000_0000_1234, 64'd0,
              64'h2340, "R2 sal equals shl");
    // R6: register count, upper bits junk, immediate ignored
    drive_exp(2'd0, 2'd3, 1'b1, 8'd5, 64'hFFFF_FFFF_FFFF_FF03, 64'd1, 64'd0,
              64'd8, "R6 reg count low byte");
    drive_exp(2'd0, 2'd3, 1'b0, 8'd2, 64'hFFFF_FFFF_FFFF_FF07, 64'd1, 64'd0,
              64'd4, "R6 imm count reg ignored");
    // R9: masked count zero passes operand
    drive_exp(2'd1, 2'd0, 1'b0, 8'd8, 64'd0, 64'h0000_0000_0000_00A5,
              64'h0102_0304_0506_0708, 64'h0102_0304_0506_07A5, "R9 byte count 8");
    drive_exp(2'd2, 2'd3, 1'b1, 8'd0, 64'h0000_0000_0000_0040, 64'h8765_4321_0FED_CBA9,
              64'd0, 64'h8765_4321_0FED_CBA9, "R9 quad count 64");

    // mixed patterns against the model
    for (int i = 0; i < 48; i++) begin
      drive(2'($urandom), 2'($urandom), 1'($urandom), 8'($urandom),
            {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
            "R1 R5 R7 R8 mixed");
    end

    // R10: idle cycles hold the result
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    held = result;
    operand = 64'hDEAD_BEEF_DEAD_BEEF;
    repeat (3) @(negedge clk);
    check("R10 hold result", result, held);
    check("R10 out_valid low", {63'd0, out_valid}, 64'd0);
    check("R10 queue drained", 64'(exp_q.size()), 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule